// File: doc/BRIEF.md
# Dual-Channel Reloadable Down-Counting Timer

This block is a register-mapped timer with two independent 32-bit channels. Each channel has a counter that steps down by one on every selected tick. The tick comes either from every clock or from a slow tick-enable strobe supplied from outside. When a channel expires, it raises a sticky status flag. That flag, gated by an enable bit, drives the channel's interrupt line.

Software programs each channel through three registers:
- A control word, reachable at a plain-write address, an OR-in address and an AND-NOT address.
- A read-only view of the running count.
- A fixed count that acts as the reload value.

A channel in reload mode runs continuously with a period equal to its fixed count. Otherwise it stops at zero after one expiry, which suits one-shot delays. With the update bit set, a write to the fixed count takes effect in the running counter at once. Without it, the new value waits for the next reload. A read-only identification word reports major version 2.

The bus is a single-cycle write strobe with a combinational read port. A write lands on the clock edge at which `bus_wen` is high. A read returns the addressed word in the same cycle.

Top module: `tmr_block`

## Requirements
- R1: After reset, every control word, running count and fixed count reads zero, and both interrupt outputs are low.
- R2: The tick source is the control word's bits [3:0]. Value 0xF ticks on every clock. Value 0xB ticks only on clock edges where `slow_tick` is high. Any other value never ticks, so the count holds.
- R3: Each tick lowers a running count above 1 by exactly one. A channel with the reload bit (bit 6) clear holds at zero after expiry.
- R4: A tick while the running count is 1 is an expiry. An expiry sets the sticky status bit (bit 15). `irq[n]` is high exactly when channel n's status bit and interrupt-enable bit (bit 14) are both set.
- R5: With the reload bit set, an expiry loads the running count from the fixed count. A tick while the count is 0 also loads it. The all-ones fixed count gives the longest period.
- R6: A write to the fixed count with the update bit (bit 7) set loads the running count at the same edge. This takes priority over any tick, and no expiry occurs in that cycle. With update clear, the running count is unaffected.
- R7: Channel n's control word is at 0x20+n*0x40 (plain write replaces it), +0x4 (written data is ORed in) and +0x8 (written ones are cleared). Reads at any of the three addresses return the word. Only bits 15, 14, 7, 6 and 3:0 are stored; all other bits read 0.
- R8: When an expiry and a clear of the status bit through the clear alias fall on the same edge, the status bit ends up set.
- R9: The running count reads at 0x30+n*0x40 and ignores writes. The fixed count is read and written at 0x40+n*0x40. A write to one channel never changes the other.
- R10: Address 0xA0 reads 0x0200_0000 (major version 2 in bits 31:24). Address 0x00 and unmapped addresses read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | Slow tick-enable strobe, one clock wide per slow tick |
| bus_wen | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 2 | Per-channel interrupt, status AND enable |

## Verification
Two functions can collide on channel 0 on one edge: a hardware expiry and a software clear of the status bit through the clear alias. The bench programs a count of 3 with every-clock ticking and update set. It waits two edges, then issues the clear-alias write on the third edge, exactly when the count steps from 1.

After that edge, the control word must still show bit 15 set, and the running count must have reloaded to 3. The bench judges both values against its own cycle-accurate model and against literal expectations. The same model also checks a fixed-count write with update set against a pending tick, on every clock through the interrupt outputs.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ADDR_W = 8;
    localparam int REG_W  = 32;

    localparam logic [ADDR_W-1:0] CH_STRIDE = 8'h40;
    localparam logic [ADDR_W-1:0] CTRL_OFS  = 8'h20;
    localparam logic [ADDR_W-1:0] CNT_OFS   = 8'h30;
    localparam logic [ADDR_W-1:0] FIX_OFS   = 8'h40;
    localparam logic [ADDR_W-1:0] SET_OFS   = 8'h04;
    localparam logic [ADDR_W-1:0] CLR_OFS   = 8'h08;
    localparam logic [ADDR_W-1:0] VER_ADDR  = 8'hA0;
    localparam logic [7:0]        VER_MAJOR = 8'h02;

    localparam logic [3:0] SEL_EVERY = 4'hF;
    localparam logic [3:0] SEL_SLOW  = 4'hB;

    localparam int B_RELOAD = 6;
    localparam int B_UPDATE = 7;
    localparam int B_IEN    = 14;
    localparam int B_STAT   = 15;

    typedef struct packed {
        logic       stat;
        logic       ien;
        logic       update;
        logic       reload;
        logic [3:0] sel;
    } ctrl_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_WRITE,
        OP_SET,
        OP_CLR
    } ctrl_op_e;

    function automatic logic [REG_W-1:0] ctrl_to_word(ctrl_t c);
        logic [REG_W-1:0] w;
        w           = '0;
        w[3:0]      = c.sel;
        w[B_RELOAD] = c.reload;
        w[B_UPDATE] = c.update;
        w[B_IEN]    = c.ien;
        w[B_STAT]   = c.stat;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(logic [REG_W-1:0] w);
        ctrl_t c;
        c.sel    = w[3:0];
        c.reload = w[B_RELOAD];
        c.update = w[B_UPDATE];
        c.ien    = w[B_IEN];
        c.stat   = w[B_STAT];
        return c;
    endfunction

    function automatic ctrl_t ctrl_apply(ctrl_t cur, ctrl_op_e op, logic [REG_W-1:0] d);
        ctrl_t m;
        m = word_to_ctrl(d);
        case (op)
            OP_WRITE: return m;
            OP_SET:   return ctrl_t'(cur | m);
            OP_CLR:   return ctrl_t'(cur & ~m);
            default:  return cur;
        endcase
    endfunction

    function automatic logic tick_pick(logic [3:0] sel, logic slow);
        case (sel)
            SEL_EVERY: return 1'b1;
            SEL_SLOW:  return slow;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] chan_addr(int n, logic [ADDR_W-1:0] ofs);
        return ofs + ADDR_W'(n * int'(CH_STRIDE));
    endfunction

endpackage

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int CNT_W = 32
) (
    input  logic                        bus_wen,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [NCH-1:0][REG_W-1:0]   ctrl_words,
    input  logic [NCH-1:0][CNT_W-1:0]   cnt_vals,
    input  logic [NCH-1:0][CNT_W-1:0]   fix_vals,
    output ctrl_op_e [NCH-1:0]          ctrl_op,
    output logic [NCH-1:0]              fix_we,
    output logic [REG_W-1:0]            bus_rdata
);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == VER_ADDR)
            bus_rdata = REG_W'({VER_MAJOR, 24'h000000});
        for (int i = 0; i < NCH; i++) begin
            ctrl_op[i] = OP_NONE;
            fix_we[i]  = 1'b0;
            if (bus_wen) begin
                if (bus_addr == chan_addr(i, CTRL_OFS))
                    ctrl_op[i] = OP_WRITE;
                else if (bus_addr == chan_addr(i, CTRL_OFS + SET_OFS))
                    ctrl_op[i] = OP_SET;
                else if (bus_addr == chan_addr(i, CTRL_OFS + CLR_OFS))
                    ctrl_op[i] = OP_CLR;
                fix_we[i] = (bus_addr == chan_addr(i, FIX_OFS));
            end
            if ((bus_addr == chan_addr(i, CTRL_OFS)) ||
                (bus_addr == chan_addr(i, CTRL_OFS + SET_OFS)) ||
                (bus_addr == chan_addr(i, CTRL_OFS + CLR_OFS)))
                bus_rdata = ctrl_words[i];
            else if (bus_addr == chan_addr(i, CNT_OFS))
                bus_rdata = REG_W'(cnt_vals[i]);
            else if (bus_addr == chan_addr(i, FIX_OFS))
                bus_rdata = REG_W'(fix_vals[i]);
        end
    end

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_op_e          op,
    input  logic [REG_W-1:0]  wdata,
    input  logic              expire,
    output ctrl_t             ctrl_q
);

    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_apply(ctrl_q, op, wdata);
        // hardware expiry outranks a software clear on the same edge
        if (expire)
            ctrl_d.stat = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else
            ctrl_q <= ctrl_d;
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             reload_en,
    input  logic             update_en,
    input  logic             fix_we,
    input  logic [CNT_W-1:0] fix_wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] fix_q,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             load_now;
    logic             at_one;
    logic             at_zero;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] fix_d;
    logic [CNT_W-1:0] wrap_val;

    assign load_now = fix_we && update_en;
    assign at_one   = (cnt_q == ONE);
    assign at_zero  = (cnt_q == '0);
    assign expire   = tick && at_one && !load_now;
    assign wrap_val = reload_en ? fix_q : '0;

    always_comb begin
        cnt_d = cnt_q;
        if (load_now)
            cnt_d = fix_wdata;
        else if (tick) begin
            if (at_one || at_zero)
                cnt_d = wrap_val;
            else
                cnt_d = cnt_q - ONE;
        end
        fix_d = fix_we ? fix_wdata : fix_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            fix_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            fix_q <= fix_d;
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_tick,
    input  ctrl_op_e          op,
    input  logic              fix_we,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  ctrl_word,
    output logic [CNT_W-1:0]  cnt_val,
    output logic [CNT_W-1:0]  fix_val,
    output logic              irq
);

    ctrl_t ctrl_q;
    logic  tick;
    logic  expire;

    assign tick = tick_pick(ctrl_q.sel, slow_tick);

    tmr_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .wdata  (wdata),
        .expire (expire),
        .ctrl_q (ctrl_q)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .reload_en (ctrl_q.reload),
        .update_en (ctrl_q.update),
        .fix_we    (fix_we),
        .fix_wdata (wdata[CNT_W-1:0]),
        .cnt_q     (cnt_val),
        .fix_q     (fix_val),
        .expire    (expire)
    );

    assign ctrl_word = ctrl_to_word(ctrl_q);
    assign irq       = ctrl_q.stat & ctrl_q.ien;

endmodule

// File: rtl/tmr_block.sv
module tmr_block
    import tmr_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_tick,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [NCH-1:0]    irq
);

    ctrl_op_e [NCH-1:0]        ctrl_op;
    logic [NCH-1:0]            fix_we;
    logic [NCH-1:0][REG_W-1:0] ctrl_words;
    logic [NCH-1:0][CNT_W-1:0] cnt_vals;
    logic [NCH-1:0][CNT_W-1:0] fix_vals;

    tmr_regif #(.NCH(NCH), .CNT_W(CNT_W)) u_regif (
        .bus_wen    (bus_wen),
        .bus_addr   (bus_addr),
        .ctrl_words (ctrl_words),
        .cnt_vals   (cnt_vals),
        .fix_vals   (fix_vals),
        .ctrl_op    (ctrl_op),
        .fix_we     (fix_we),
        .bus_rdata  (bus_rdata)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .slow_tick (slow_tick),
            .op        (ctrl_op[i]),
            .fix_we    (fix_we[i]),
            .wdata     (bus_wdata),
            .ctrl_word (ctrl_words[i]),
            .cnt_val   (cnt_vals[i]),
            .fix_val   (fix_vals[i]),
            .irq       (irq[i])
        );
    end

endmodule

// File: rtl/tmr_block_chk.sv
module tmr_block_chk
    import tmr_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int CNT_W = 32
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      bus_wen,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [REG_W-1:0]          bus_wdata,
    input logic [NCH-1:0]            irq,
    input logic [NCH-1:0][REG_W-1:0] ctrl_words,
    input logic [NCH-1:0][CNT_W-1:0] cnt_vals
);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (irq == '0 && cnt_vals == '0 && ctrl_words == '0)); // R1

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        logic fix_hit;
        logic stat_cleared;
        assign fix_hit = bus_wen && (bus_addr == chan_addr(n, FIX_OFS));
        assign stat_cleared = bus_wen &&
            (((bus_addr == chan_addr(n, CTRL_OFS)) && !bus_wdata[B_STAT]) ||
             ((bus_addr == chan_addr(n, CTRL_OFS + CLR_OFS)) && bus_wdata[B_STAT]));

        AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
            (ctrl_words[n][3:0] == SEL_EVERY && cnt_vals[n] > CNT_W'(1) && !fix_hit)
            |=> cnt_vals[n] == CNT_W'($past(cnt_vals[n]) - CNT_W'(1))); // R2

        AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
            (cnt_vals[n] == '0 && !ctrl_words[n][B_RELOAD] && !fix_hit)
            |=> cnt_vals[n] == '0); // R3

        AST_STICKY_STAT: assert property (@(posedge clk) disable iff (rst)
            (ctrl_words[n][B_STAT] && !stat_cleared) |=> ctrl_words[n][B_STAT]); // R4

        AST_EXPIRY_WINS: assert property (@(posedge clk) disable iff (rst)
            (ctrl_words[n][3:0] == SEL_EVERY && cnt_vals[n] == CNT_W'(1) && !fix_hit)
            |=> ctrl_words[n][B_STAT]); // R8
    end

endmodule

bind tmr_block tmr_block_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wen    (bus_wen),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .irq        (irq),
    .ctrl_words (ctrl_words),
    .cnt_vals   (cnt_vals)
);

// File: tb/sim_tmr_block.sv
`timescale 1ns/100ps
module sim_tmr_block;

    localparam logic [31:0] MASK = 32'h0000_C0CF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_tick = 1'b0;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [31:0] m_ctrl [2];
    logic [31:0] m_cnt  [2];
    logic [31:0] m_fix  [2];

    tmr_block u0 (
        .clk       (clk),
        .rst       (rst),
        .slow_tick (slow_tick),
        .bus_wen   (bus_wen),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #2 clk = ~clk;

    // behavioural reference model, advanced on every clock edge
    always @(posedge clk) begin
        logic [31:0] cb, fb, nc, nn;
        logic tk, ld, ex;
        for (int n = 0; n < 2; n++) begin
            if (rst) begin
                m_ctrl[n] = 32'h0;
                m_cnt[n]  = 32'h0;
                m_fix[n]  = 32'h0;
            end else begin
                cb = 32'h20 + n * 32'h40;
                fb = 32'h40 + n * 32'h40;
                tk = (m_ctrl[n][3:0] == 4'hF) || (m_ctrl[n][3:0] == 4'hB && slow_tick);
                ld = bus_wen && ({24'h0, bus_addr} == fb) && m_ctrl[n][7];
                ex = tk && (m_cnt[n] == 32'd1) && !ld;
                nc = m_ctrl[n];
                if (bus_wen && {24'h0, bus_addr} == cb)         nc = bus_wdata & MASK;
                if (bus_wen && {24'h0, bus_addr} == cb + 32'h4) nc = nc | (bus_wdata & MASK);
                if (bus_wen && {24'h0, bus_addr} == cb + 32'h8) nc = nc & ~bus_wdata;
                if (ex) nc[15] = 1'b1;
                nn = m_cnt[n];
                if (ld) nn = bus_wdata;
                else if (tk) begin
                    if (m_cnt[n] <= 32'd1) nn = m_ctrl[n][6] ? m_fix[n] : 32'h0;
                    else nn = m_cnt[n] - 32'd1;
                end
                if (bus_wen && {24'h0, bus_addr} == fb) m_fix[n] = bus_wdata;
                m_ctrl[n] = nc;
                m_cnt[n]  = nn;
            end
        end
    end

    function automatic logic [31:0] model_read(logic [7:0] a);
        logic [31:0] r;
        r = 32'h0;
        if (a == 8'hA0) r = 32'h0200_0000;
        for (int n = 0; n < 2; n++) begin
            if (a == 8'(32'h20 + n * 32'h40) || a == 8'(32'h24 + n * 32'h40) ||
                a == 8'(32'h28 + n * 32'h40)) r = m_ctrl[n];
            if (a == 8'(32'h30 + n * 32'h40)) r = m_cnt[n];
            if (a == 8'(32'h40 + n * 32'h40)) r = m_fix[n];
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // interrupt outputs compared to the model on every clock
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R4 irq per clock", {30'h0, irq},
                {30'h0, m_ctrl[1][15] & m_ctrl[1][14], m_ctrl[0][15] & m_ctrl[0][14]});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            nerr++;
            nchk++;
            $display("FAIL R1 watchdog actual=%0d expected<=%0d", cyc, 50000);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wen   = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        @(negedge clk);
        bus_wen  = 1'b0;
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, model_read(a));
    endtask

    task automatic rd_lit(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_wen  = 1'b0;
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic pulse();
        @(negedge clk);
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state, version and root
        rd_lit(8'h20, 32'h0, "R1 ctrl0 after reset");
        rd_lit(8'h30, 32'h0, "R1 count0 after reset");
        rd_lit(8'h80, 32'h0, "R1 fixed1 after reset");
        chk("R1 irq after reset", {30'h0, irq}, 32'h0);
        rd_lit(8'hA0, 32'h0200_0000, "R10 version word");

        // fixed write without update leaves running count alone
        wr(8'h40, 32'd5);
        rd_lit(8'h30, 32'h0, "R6 no update keeps count");
        rd_lit(8'h40, 32'd5, "R9 fixed0 readback");
        wr(8'h24, 32'h0000_0080);
        rd_lit(8'h20, 32'h0000_0080, "R7 set alias ORs bit");
        wr(8'h40, 32'd5);
        rd_lit(8'h30, 32'd5, "R6 update loads count");

        // one-shot on every clock
        wr(8'h24, 32'h0000_400F);
        idle(8);
        rd_lit(8'h30, 32'h0, "R3 one-shot holds at zero");
        rd_lit(8'h20, 32'h0000_C08F, "R4 status bit set");
        chk("R4 irq0 high", {31'h0, irq[0]}, 32'h1);
        wr(8'h28, 32'h0000_8000);
        rd_lit(8'h20, 32'h0000_408F, "R7 clear alias");
        chk("R4 irq0 low after clear", {31'h0, irq[0]}, 32'h0);

        // running count ignores writes
        wr(8'h30, 32'h1234_5678);
        rd_lit(8'h30, 32'h0, "R9 running count read-only");

        // plain write keeps only the defined bits
        wr(8'h20, 32'hFFFF_FFFF);
        rd_lit(8'h20, 32'h0000_C0CF, "R7 plain write mask");
        wr(8'h28, 32'h0000_8000);

        // expiry against clear alias on the same edge
        wr(8'h40, 32'd3);
        idle(2);
        wr(8'h28, 32'h0000_8000);
        rd_lit(8'h30, 32'd3, "R5 reload from fixed at expiry");
        @(negedge clk);
        bus_addr = 8'h20;
        #1;
        chk("R8 expiry beats clear", bus_rdata & 32'h0000_8000, 32'h0000_8000);
        idle(20);
        rd(8'h30, "R5 periodic count");
        rd(8'h20, "R5 periodic ctrl");

        // slow tick source on channel 1
        wr(8'h60, 32'h0000_408B);
        wr(8'h80, 32'd4);
        idle(6);
        rd_lit(8'h70, 32'd4, "R2 slow source idle");
        pulse();
        pulse();
        pulse();
        rd_lit(8'h70, 32'd1, "R2 slow source three ticks");
        pulse();
        rd_lit(8'h70, 32'd0, "R2 slow source expiry");
        chk("R4 irq1 high", {31'h0, irq[1]}, 32'h1);

        // unused select code never ticks
        wr(8'h68, 32'h0000_000F);
        wr(8'h64, 32'h0000_0003);
        wr(8'h80, 32'd9);
        pulse();
        pulse();
        idle(3);
        rd_lit(8'h70, 32'd9, "R2 other select holds");

        // maximum period
        wr(8'h64, 32'h0000_000C);
        wr(8'h80, 32'hFFFF_FFFF);
        rd_lit(8'h70, 32'hFFFF_FFFF, "R5 all-ones load");
        idle(10);
        rd(8'h70, "R3 decrement from all-ones");

        // update cleared: fixed write waits for reload
        wr(8'h68, 32'h0000_0080);
        wr(8'h80, 32'd7);
        rd(8'h70, "R6 count unaffected without update");
        rd_lit(8'h80, 32'd7, "R9 fixed1 readback");

        // independence, root and unmapped addresses
        rd(8'h24, "R9 ctrl0 via set alias");
        rd(8'h68, "R9 ctrl1 via clear alias");
        wr(8'h00, 32'hFFFF_FFFF);
        rd_lit(8'h00, 32'h0, "R10 root reads zero");
        wr(8'h90, 32'hFFFF_FFFF);
        rd_lit(8'h90, 32'h0, "R10 unmapped reads zero");
        rd(8'h30, "R9 count0 after other writes");

        idle(4);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule